// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, frame by frame, whether an incoming Ethernet frame is kept. The six destination address bytes are streamed in one per cycle, first byte first. On the last byte the block combines the destination with the frame length, the station address, the mode bits and the receiver and link state. One cycle later it gives a registered verdict: a strobe, an accept bit, and a flag that marks an accepted broadcast or group frame.

Group (multicast) destinations are matched through a 64-bit hash table. The table is filled by a load sequence: a start pulse carries a byte count, and the list of 6-byte group addresses then follows one byte per cycle. Each loaded address sets one table bit. The bit is chosen by the same CRC-derived 6-bit index that the frame path computes. Frame storage and memory transfer are handled elsewhere.

Top module: `rx_addr_filter`

## Requirements
- R1: When `rx_ready_i` is low or `link_up_i` is low at the last destination byte, the frame is rejected whatever its address or mode.
- R2: A frame is rejected when `frame_len_i` is below the effective minimum. The effective minimum is `min_len_i` raised to 5 when it is smaller than 5. A length equal to the effective minimum passes.
- R3: With `cfg_promisc_i` set, every frame that passes R1 and R2 is accepted, and `group_o` stays 0.
- R4: A destination of all ones is broadcast. It is rejected when `cfg_bcast_dis_i` is set. Otherwise it is accepted with `group_o` = 1.
- R5: A destination that is not broadcast but has bit 0 of its first byte set is a group address. Such a frame is rejected when `cfg_mcast_en_i` is clear, whatever the table holds.
- R6: For a group address with `cfg_mcast_en_i` set, a CRC is computed over the six destination bytes. The CRC uses polynomial 0x04C11DB7 and starts from all ones. Each byte is fed least significant bit first, and no final inversion is applied. CRC bits [7:2] form the index into the 64-bit table. The frame is accepted, with `group_o` = 1, exactly when the indexed bit is set.
- R7: Any other destination is unicast. It is accepted, with `group_o` = 0, only when all 48 bits equal `station_addr_i`. Byte k of the address, counted in stream order from 0, sits at `station_addr_i[8k+7:8k]`.
- R8: Reset clears the whole table. A load start pulse also clears the whole table before any new entry is written.
- R9: The entry count of a load is `mc_count_i` / 6, rounded down and clamped to 64. Each entry sets the table bit chosen by the R6 index of its six bytes. Bytes that arrive after the last counted entry have no effect.
- R10: `decision_valid_o` pulses for exactly one cycle, in the cycle after the sixth destination byte. `accept_o` and `group_o` are 0 whenever `decision_valid_o` is 0.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| da_valid_i | input | 1 | Destination byte valid |
| da_byte_i | input | 8 | Destination byte, stream order |
| frame_len_i | input | 16 | Frame length in bytes, sampled at last byte |
| min_len_i | input | 8 | Configured minimum frame length |
| station_addr_i | input | 48 | Own individual address, byte 0 in [7:0] |
| cfg_promisc_i | input | 1 | Accept all frames passing length and link checks |
| cfg_bcast_dis_i | input | 1 | Reject broadcast frames |
| cfg_mcast_en_i | input | 1 | Allow group frames through the hash table |
| rx_ready_i | input | 1 | Receiver ready (low means suspended) |
| link_up_i | input | 1 | Link is up |
| mc_start_i | input | 1 | Start of table load; clears the table |
| mc_count_i | input | 16 | Byte count of the list, sampled with the start pulse |
| mc_valid_i | input | 1 | List byte valid |
| mc_byte_i | input | 8 | List byte |
| decision_valid_o | output | 1 | Verdict strobe |
| accept_o | output | 1 | Frame accepted |
| group_o | output | 1 | Accepted frame is broadcast or group |

## Verification
The bench targets several corner cases. The first is the minimum-length floor: a design that skipped the raise to 5 would pass a 4-byte frame, and an off-by-one compare would drop a frame of exactly the minimum length. The second is a byte count that is not a multiple of 6 or that lists more than 64 addresses; a design that rounded up or did not clamp would set bits for the partial or surplus addresses, so frames to those addresses would pass. The bench also reloads a short list over a full one, which shows whether a design forgets to clear the old bits. Finally, it crosses group, broadcast and promiscuous frames with every mode bit. A wrong priority shows up as a group flag raised in promiscuous mode, or as group frames passing with the enable clear.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTE_W        = 8;
  localparam int ADDR_BYTES    = 6;
  localparam int ADDR_W        = ADDR_BYTES * BYTE_W;
  localparam int CRC_W         = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam int HASH_LSB      = 2;
  localparam int HASH_W        = 6;
  localparam int TABLE_BITS    = 1 << HASH_W;
  localparam int MIN_LEN_FLOOR = 5;
  localparam int POS_W         = $clog2(ADDR_BYTES);

  typedef logic [HASH_W-1:0] hash_idx_t;

  // bit-serial CRC over one byte, lsb first, no inversion
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c_in,
                                                     input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int j = 0; j < BYTE_W; j++) begin
      fb = c[CRC_W-1] ^ d[j];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              first_i,
  input  logic [BYTE_W-1:0] byte_i,
  output hash_idx_t         idx_nxt_o
);
  logic [CRC_W-1:0] crc_q, crc_base, crc_nxt;

  assign crc_base  = first_i ? '1 : crc_q;
  assign crc_nxt   = crc_step_byte(crc_base, byte_i);
  assign idx_nxt_o = crc_nxt[HASH_LSB +: HASH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '1;
    else if (en_i) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table
  import rxf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      set_i,
  input  hash_idx_t set_idx_i,
  input  hash_idx_t look_idx_i,
  output logic      hit_o
);
  logic [TABLE_BITS-1:0] tbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tbl_q <= '0;
    else if (clr_i)  tbl_q <= '0;
    else if (set_i)  tbl_q[set_idx_i] <= 1'b1;
  end

  assign hit_o = tbl_q[look_idx_i];

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (tbl_q == '0));

  assert_set_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> tbl_q[$past(set_idx_i)]);

  assert_set_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> ($countones(tbl_q) >= $countones($past(tbl_q))));
endmodule

// File: rtl/rxf_mc_loader.sv
module rxf_mc_loader
  import rxf_pkg::*;
#(
  parameter int MC_MAX  = 64,
  parameter int COUNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COUNT_W-1:0] count_i,
  input  logic               byte_valid_i,
  input  logic [BYTE_W-1:0]  byte_i,
  output logic               clr_o,
  output logic               set_o,
  output hash_idx_t          set_idx_o
);
  localparam int ENT_W = $clog2(MC_MAX + 1);
  localparam logic [COUNT_W-1:0] MAX_C = COUNT_W'(MC_MAX);
  localparam logic [POS_W-1:0]   LAST_POS = POS_W'(ADDR_BYTES - 1);

  logic [COUNT_W-1:0] quot;
  logic [ENT_W-1:0]   clamped, left_q;
  logic [POS_W-1:0]   pos_q;
  logic               take, last_b;
  hash_idx_t          idx_nxt;

  assign quot    = count_i / COUNT_W'(ADDR_BYTES);
  assign clamped = (quot > MAX_C) ? ENT_W'(MC_MAX) : quot[ENT_W-1:0];
  assign take    = byte_valid_i && (left_q != '0) && !start_i;
  assign last_b  = (pos_q == LAST_POS);

  rxf_crc_hash u_crc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (take),
    .first_i   (pos_q == '0),
    .byte_i    (byte_i),
    .idx_nxt_o (idx_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      pos_q  <= '0;
    end else if (start_i) begin
      left_q <= clamped;
      pos_q  <= '0;
    end else if (take) begin
      if (last_b) begin
        pos_q  <= '0;
        left_q <= left_q - 1'b1;
      end else begin
        pos_q  <= pos_q + 1'b1;
      end
    end
  end

  assign clr_o     = start_i;
  assign set_o     = take && last_b;
  assign set_idx_o = idx_nxt;

  assert_entry_clamp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= ENT_W'(MC_MAX));

  assert_no_set_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q == '0) |-> !set_o);
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              da_valid_i,
  input  logic [BYTE_W-1:0] da_byte_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic [BYTE_W-1:0] min_len_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              cfg_promisc_i,
  input  logic              cfg_bcast_dis_i,
  input  logic              cfg_mcast_en_i,
  input  logic              rx_ready_i,
  input  logic              link_up_i,
  input  logic              mc_hit_i,
  output hash_idx_t         look_idx_o,
  output logic              valid_o,
  output logic              accept_o,
  output logic              group_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);

  logic [POS_W-1:0]         cnt_q;
  logic [ADDR_W-BYTE_W-1:0] da_q;
  logic [ADDR_W-1:0]        full_da;
  logic [BYTE_W-1:0]        eff_min;
  logic last, is_bcast, is_mcast, len_ok, acc, grp;
  logic valid_q, acc_q, grp_q;

  assign last = da_valid_i && (cnt_q == LAST_POS);

  rxf_crc_hash u_crc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (da_valid_i),
    .first_i   (cnt_q == '0),
    .byte_i    (da_byte_i),
    .idx_nxt_o (look_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      da_q  <= '0;
    end else if (da_valid_i) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      for (int k = 0; k < ADDR_BYTES - 1; k++)
        if (cnt_q == POS_W'(k)) da_q[k*BYTE_W +: BYTE_W] <= da_byte_i;
    end
  end

  assign full_da  = {da_byte_i, da_q};
  assign is_bcast = &full_da;
  assign is_mcast = full_da[0] && !is_bcast;
  assign eff_min  = (min_len_i < BYTE_W'(MIN_LEN_FLOOR)) ? BYTE_W'(MIN_LEN_FLOOR) : min_len_i;
  assign len_ok   = frame_len_i >= LEN_W'(eff_min);

  always_comb begin
    acc = 1'b0;
    grp = 1'b0;
    if (!rx_ready_i || !link_up_i || !len_ok) begin
      acc = 1'b0;
    end else if (cfg_promisc_i) begin
      acc = 1'b1;
    end else if (is_bcast) begin
      acc = !cfg_bcast_dis_i;
      grp = !cfg_bcast_dis_i;
    end else if (is_mcast) begin
      acc = cfg_mcast_en_i && mc_hit_i;
      grp = cfg_mcast_en_i && mc_hit_i;
    end else begin
      acc = (full_da == station_addr_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
      grp_q   <= 1'b0;
    end else begin
      valid_q <= last;
      acc_q   <= last && acc;
      grp_q   <= last && grp;
    end
  end

  assign valid_o  = valid_q;
  assign accept_o = acc_q;
  assign group_o  = grp_q;

  assert_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && (!rx_ready_i || !link_up_i)) |=> !accept_o);

  assert_len_floor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && (frame_len_i < LEN_W'(MIN_LEN_FLOOR))) |=> !accept_o);

  assert_promisc_grp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && cfg_promisc_i) |=> !group_o);

  assert_mcast_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && is_mcast && !cfg_mcast_en_i && !cfg_promisc_i) |=> !accept_o);

  assert_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_acc_in_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o || group_o) |-> valid_o);

  assert_grp_acc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    group_o |-> accept_o);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int MC_MAX_ENTRIES = 64,
  parameter int LEN_W          = 16,
  parameter int COUNT_W        = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               da_valid_i,
  input  logic [7:0]         da_byte_i,
  input  logic [LEN_W-1:0]   frame_len_i,
  input  logic [7:0]         min_len_i,
  input  logic [47:0]        station_addr_i,
  input  logic               cfg_promisc_i,
  input  logic               cfg_bcast_dis_i,
  input  logic               cfg_mcast_en_i,
  input  logic               rx_ready_i,
  input  logic               link_up_i,
  input  logic               mc_start_i,
  input  logic [COUNT_W-1:0] mc_count_i,
  input  logic               mc_valid_i,
  input  logic [7:0]         mc_byte_i,
  output logic               decision_valid_o,
  output logic               accept_o,
  output logic               group_o
);
  logic      tbl_clr, tbl_set, mc_hit;
  hash_idx_t set_idx, look_idx;

  rxf_mc_loader #(.MC_MAX(MC_MAX_ENTRIES), .COUNT_W(COUNT_W)) u_loader (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (mc_start_i),
    .count_i      (mc_count_i),
    .byte_valid_i (mc_valid_i),
    .byte_i       (mc_byte_i),
    .clr_o        (tbl_clr),
    .set_o        (tbl_set),
    .set_idx_o    (set_idx)
  );

  rxf_hash_table u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (tbl_clr),
    .set_i      (tbl_set),
    .set_idx_i  (set_idx),
    .look_idx_i (look_idx),
    .hit_o      (mc_hit)
  );

  rxf_decide #(.LEN_W(LEN_W)) u_decide (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .da_valid_i      (da_valid_i),
    .da_byte_i       (da_byte_i),
    .frame_len_i     (frame_len_i),
    .min_len_i       (min_len_i),
    .station_addr_i  (station_addr_i),
    .cfg_promisc_i   (cfg_promisc_i),
    .cfg_bcast_dis_i (cfg_bcast_dis_i),
    .cfg_mcast_en_i  (cfg_mcast_en_i),
    .rx_ready_i      (rx_ready_i),
    .link_up_i       (link_up_i),
    .mc_hit_i        (mc_hit),
    .look_idx_o      (look_idx),
    .valid_o         (decision_valid_o),
    .accept_o        (accept_o),
    .group_o         (group_o)
  );
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        da_valid = 1'b0;
  logic [7:0]  da_byte = '0;
  logic [15:0] frame_len = 16'd64;
  logic [7:0]  min_len = 8'd5;
  logic [47:0] station = 48'h5634_1200_AA02;
  logic        promisc = 1'b0, bdis = 1'b0, men = 1'b0, ready = 1'b1, link = 1'b1;
  logic        mc_start = 1'b0, mc_valid = 1'b0;
  logic [15:0] mc_count = '0;
  logic [7:0]  mc_byte = '0;
  logic        dv, acc, grp;

  logic [63:0] model_tbl = '0;
  logic [47:0] mc_list [0:79];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .da_valid_i(da_valid), .da_byte_i(da_byte),
    .frame_len_i(frame_len), .min_len_i(min_len), .station_addr_i(station),
    .cfg_promisc_i(promisc), .cfg_bcast_dis_i(bdis), .cfg_mcast_en_i(men),
    .rx_ready_i(ready), .link_up_i(link), .mc_start_i(mc_start),
    .mc_count_i(mc_count), .mc_valid_i(mc_valid), .mc_byte_i(mc_byte),
    .decision_valid_o(dv), .accept_o(acc), .group_o(grp)
  );

  function automatic logic [5:0] hash_of(input logic [47:0] a);
    logic [31:0] c = '1;
    logic fb;
    for (int k = 0; k < 48; k++) begin
      fb = c[31] ^ a[k];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c[7:2];
  endfunction

  function automatic logic [47:0] rnd48();
    logic [63:0] t = {$urandom(), $urandom()};
    return t[47:0];
  endfunction

  function automatic logic [47:0] rnd_group();
    logic [47:0] a = rnd48();
    a[0] = 1'b1;
    a[47] = 1'b0;
    return a;
  endfunction

  // expected {accept, group}
  function automatic logic [1:0] expect_of(input logic [47:0] a, input logic [15:0] len);
    int floor_len = (min_len < 8'd5) ? 5 : int'(min_len);
    if (!ready || !link) return 2'b00;
    if (int'(len) < floor_len) return 2'b00;
    if (promisc) return 2'b10;
    if (a == '1) return bdis ? 2'b00 : 2'b11;
    if (a[0]) return (men && model_tbl[hash_of(a)]) ? 2'b11 : 2'b00;
    return (a == station) ? 2'b10 : 2'b00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [47:0] a, input logic [15:0] len, input string req);
    logic [1:0] e;
    frame_len = len;
    e = expect_of(a, len);
    for (int k = 0; k < 6; k++) begin
      da_valid = 1'b1;
      da_byte  = a[8*k +: 8];
      @(negedge clk);
      if (k < 5 && dv !== 1'b0) check({req, " R10 early strobe"}, 32'(dv), 32'd0);
    end
    da_valid = 1'b0;
    check({req, " R10 strobe"}, 32'(dv), 32'd1);
    check({req, " accept/group"}, {30'd0, acc, grp}, {30'd0, e});
    @(negedge clk);
    check({req, " R10 strobe drop"}, {29'd0, dv, acc, grp}, 32'd0);
  endtask

  task automatic load_list(input int count);
    int n;
    mc_start = 1'b1;
    mc_count = 16'(count);
    @(negedge clk);
    mc_start = 1'b0;
    for (int b = 0; b < count; b++) begin
      mc_valid = 1'b1;
      mc_byte  = (b / 6 < 80) ? mc_list[b / 6][8*(b % 6) +: 8] : 8'($urandom());
      @(negedge clk);
    end
    mc_valid = 1'b0;
    @(negedge clk);
    n = count / 6;
    if (n > 64) n = 64;
    model_tbl = '0;
    for (int i = 0; i < n; i++) model_tbl[hash_of(mc_list[i])] = 1'b1;
  endtask

  task automatic fill_list();
    for (int i = 0; i < 80; i++) mc_list[i] = rnd_group();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {29'd0, dv, acc, grp}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    fill_list();

    // R8: table empty after reset
    men = 1'b1;
    send_frame(mc_list[0], 16'd64, "R8 empty table after reset");

    // R9: 20 bytes -> 3 entries, partial fourth ignored
    load_list(20);
    for (int i = 0; i < 4; i++) send_frame(mc_list[i], 16'd64, "R9 short list");
    send_frame(mc_list[1], 16'd64, "R6 listed group accept");
    men = 1'b0;
    send_frame(mc_list[1], 16'd64, "R5 group disabled");
    men = 1'b1;

    // R4 broadcast
    send_frame('1, 16'd64, "R4 broadcast on");
    bdis = 1'b1;
    send_frame('1, 16'd64, "R4 broadcast disabled");
    bdis = 1'b0;

    // R7 unicast
    send_frame(station, 16'd64, "R7 station match");
    send_frame(station ^ 48'h0100_0000_0000, 16'd64, "R7 one bit off");

    // R1 gating
    ready = 1'b0;
    send_frame(station, 16'd64, "R1 not ready");
    ready = 1'b1; link = 1'b0;
    send_frame('1, 16'd64, "R1 link down");
    link = 1'b1;

    // R2 length floor
    min_len = 8'd2;
    send_frame(station, 16'd4, "R2 below floor");
    send_frame(station, 16'd5, "R2 at floor");
    min_len = 8'd60;
    send_frame(station, 16'd59, "R2 below min");
    send_frame(station, 16'd60, "R2 at min");
    min_len = 8'd5;

    // R3 promiscuous
    promisc = 1'b1;
    send_frame(rnd48() & ~48'h1, 16'd64, "R3 promisc unicast");
    send_frame(mc_list[30], 16'd64, "R3 promisc group");
    send_frame('1, 16'd64, "R3 promisc broadcast");
    promisc = 1'b0;

    // R9 clamp: 400 bytes -> 66 addresses, only 64 used
    fill_list();
    load_list(400);
    send_frame(mc_list[0], 16'd64, "R9 first entry");
    send_frame(mc_list[63], 16'd64, "R9 last entry");
    send_frame(mc_list[64], 16'd64, "R9 surplus entry");
    send_frame(mc_list[65], 16'd64, "R9 surplus entry");

    // R8 reload clears old bits
    begin
      logic [47:0] old_list [0:7];
      for (int i = 0; i < 8; i++) old_list[i] = mc_list[i + 10];
      fill_list();
      load_list(6);
      for (int i = 0; i < 8; i++) send_frame(old_list[i], 16'd64, "R8 reload clears");
      send_frame(mc_list[0], 16'd64, "R9 single entry");
    end

    // random mix
    fill_list();
    load_list(6 * (1 + int'($urandom_range(0, 40))) + int'($urandom_range(0, 5)));
    for (int t = 0; t < 400; t++) begin
      int kind = int'($urandom_range(0, 5));
      promisc = ($urandom_range(0, 7) == 0);
      bdis    = 1'($urandom());
      men     = ($urandom_range(0, 3) != 0);
      ready   = ($urandom_range(0, 9) != 0);
      link    = ($urandom_range(0, 9) != 0);
      min_len = 8'($urandom_range(0, 70));
      case (kind)
        0: a = '1;
        1: a = station;
        2: a = mc_list[$urandom_range(0, 79)];
        3: a = rnd_group();
        4: a = station ^ (48'h1 << $urandom_range(1, 47));
        default: a = rnd48() & ~48'h1;
      endcase
      send_frame(a, 16'($urandom_range(0, 80)), "R6 R7 random mix");
      if (t == 200) begin
        fill_list();
        load_list(int'($urandom_range(0, 500)));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule